// File: doc/BRIEF.md
# Vectored Interrupt Channel Manager

This block gathers 96 interrupt request lines into two prioritised outputs: a fast path and a normal path. Each channel has a pending flag that latches on a rising request edge and an enable bit. Each channel also has a path-select bit that steers it to the fast or the normal output. A fixed priority encoder on each path reports the winning channel as an index. The index is the channel number plus one, and zero means nothing is pending on that path. The enable bits live in separate set and clear registers, so software can change one channel without a read-modify-write sequence.

The block also keeps a table of handler vector words, one 32-bit word per channel, each stored with an even parity bit. Each cycle the vector of the winning channel is read out, with the fast path taking precedence, and its parity is checked. A mismatch sets a sticky error flag and records the byte offset of the faulty word. Software recovers by rewriting the word, which regenerates its parity, and then writing 1 to the flag register. Channel 0 is meant for the upstream high-severity error signal. Channels 0 and 1 always use the fast path.

Registers and the vector table share one word-wide read/write port. Reads are combinational, and writes take effect on the clock edge.

Top module: `icm_top`

## Requirements
- R1: After reset all enable bits, pending flags and path-select bits are 0, both indices read 0, the parity flag reads 0, the path-select register for channels 0–31 reads 0x3, and `vec_valid_o` is 0.
- R2: Writing the enable-set register of group g (byte offset 0x10+4g; group g holds channels 32g..32g+31, channel c at bit c mod 32) sets each enable bit whose data bit is 1 and leaves the others unchanged. The register reads back the enable bits.
- R3: Writing the enable-clear register of group g (offset 0x20+4g) clears each enable bit whose data bit is 1 and leaves the others unchanged. It also reads back the enable bits.
- R4: A pending flag is set at the clock edge where its request line is first seen high after being low. A request held high does not set it again. Writing 1 to a bit of the request-clear register (offset 0x40+4g, which reads back the pending flags) clears that flag, and a 0 bit has no effect. This applies to channel 0 as well.
- R5: The fast index (output and offset 0x00) and the normal index (output and offset 0x04) each give the lowest-numbered channel that is pending, enabled and routed to that path, plus one, or 0 if there is none. Channel 95 reports 96. A disabled channel stays pending but is not reported.
- R6: The path-select register (offset 0x30+4g, bit 1 = fast path, reset 0) steers each channel. Channels 0 and 1 are always on the fast path, and their select bits always read 1.
- R7: `fiq_o` is high exactly when the fast index is non-zero, and `irq_o` is high exactly when the normal index is non-zero.
- R8: One clock after an index changes, `vec_o` holds the table word of the winning channel (fast path first) and `vec_valid_o` is high. Table word c is at byte address 0x200+4c.
- R9: Each table word is stored with a parity bit that makes the 33 bits even. Driving `vec_par_flip` high during a table write inverts the stored bit. When a read-out word fails the check, the flag (offset 0x08, bit 0) is set one clock later, and the error-address register (offset 0x0C) holds 4×channel.
- R10: The parity flag stays set until a write with data bit 0 = 1 to offset 0x08. Writing 0 leaves it set.
- R11: Rewriting a table word stores fresh parity. After the flag is cleared, further read-outs of that word do not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 96 | Interrupt request lines, one per channel |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 10 | Byte address; bit 9 selects the vector table |
| bus_wdata | input | 32 | Write data |
| vec_par_flip | input | 1 | Inverts the stored parity of a table write (fault injection) |
| bus_rdata | output | 32 | Combinational read data |
| fiq_o | output | 1 | Fast path request |
| irq_o | output | 1 | Normal path request |
| fiq_idx_o | output | 7 | Fast path index (channel+1, 0 = none) |
| irq_idx_o | output | 7 | Normal path index (channel+1, 0 = none) |
| vec_o | output | 32 | Vector word of the winning channel |
| vec_valid_o | output | 1 | `vec_o` belongs to a pending channel |

## Verification
Some rules are checked by assertions on every clock. Each request line must agree with its index being non-zero. Neither index may exceed the channel count. Channels 0 and 1 may never appear on the normal index. A set or clear write must leave the written bits in the requested state on the next cycle, and the parity flag must never drop without a clear write. Other behaviour can only be shown by the bench's scenarios. These include edge-only latching of pending flags, priority among several pending channels, path steering, the one-cycle lag of the vector read-out, the captured error address after an injected parity fault, and recovery once the word is rewritten.

// File: rtl/icm_pkg.sv
`timescale 1ns/1ps
package icm_pkg;
    localparam int GRP_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 10;
    localparam int CH_W   = ADDR_W - 3;

    localparam logic [7:0] OFF_FIQIDX = 8'h00;
    localparam logic [7:0] OFF_IRQIDX = 8'h04;
    localparam logic [7:0] OFF_PFLAG  = 8'h08;
    localparam logic [7:0] OFF_PADDR  = 8'h0C;
    localparam logic [7:0] OFF_MSET   = 8'h10;
    localparam logic [7:0] OFF_MCLR   = 8'h20;
    localparam logic [7:0] OFF_PSEL   = 8'h30;
    localparam logic [7:0] OFF_RCLR   = 8'h40;

    typedef struct packed {
        logic              par;
        logic [DATA_W-1:0] word;
    } vec_entry_t;

    function automatic logic even_par(input logic [DATA_W-1:0] w);
        return ^w;
    endfunction

    function automatic logic [7:0] grp_off(input logic [7:0] base, input int g);
        return base + 8'(g * 4);
    endfunction

    function automatic logic [GRP_W-1:0] forced_mask(input int lo, input int nforced);
        logic [GRP_W-1:0] m;
        m = '0;
        for (int b = 0; b < GRP_W; b++)
            if (lo + b < nforced) m[b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/icm_req_bank.sv
`timescale 1ns/1ps
module icm_req_bank import icm_pkg::*; #(
    parameter int NUM_CH    = 96,
    parameter int FIXED_FIQ = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_in,
    input  logic              wr_en,
    input  logic [7:0]        wr_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] pend_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] fsel_o
);
    localparam int NUM_GRP = NUM_CH / GRP_W;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_W;
        localparam logic [GRP_W-1:0] FMASK = forced_mask(LO, FIXED_FIQ);

        logic [GRP_W-1:0] req_q, pend_q, mask_q, sel_q;
        logic [GRP_W-1:0] rise_w, clr_w;
        logic hit_set, hit_clr, hit_sel, hit_rclr;

        assign hit_set  = wr_en && (wr_off == grp_off(OFF_MSET, g));
        assign hit_clr  = wr_en && (wr_off == grp_off(OFF_MCLR, g));
        assign hit_sel  = wr_en && (wr_off == grp_off(OFF_PSEL, g));
        assign hit_rclr = wr_en && (wr_off == grp_off(OFF_RCLR, g));

        assign rise_w = req_in[LO +: GRP_W] & ~req_q;
        assign clr_w  = hit_rclr ? wdata : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q  <= '0;
                pend_q <= '0;
                mask_q <= '0;
                sel_q  <= '0;
            end else begin
                req_q  <= req_in[LO +: GRP_W];
                pend_q <= (pend_q & ~clr_w) | rise_w;
                if (hit_set)
                    mask_q <= mask_q | wdata;
                else if (hit_clr)
                    mask_q <= mask_q & ~wdata;
                if (hit_sel)
                    sel_q <= wdata;
            end
        end

        assign pend_o[LO +: GRP_W] = pend_q;
        assign mask_o[LO +: GRP_W] = mask_q;
        assign fsel_o[LO +: GRP_W] = sel_q | FMASK;
    end
endmodule

// File: rtl/icm_prio_enc.sv
`timescale 1ns/1ps
module icm_prio_enc #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (vec[i]) idx = IDX_W'(i + 1);
    end
endmodule

// File: rtl/icm_vec_table.sv
`timescale 1ns/1ps
module icm_vec_table import icm_pkg::*; #(
    parameter int NUM_CH = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wdata,
    input  logic              par_flip,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_word,
    input  logic              sel_valid,
    input  logic [CH_W-1:0]   sel_ch,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_valid_o,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic [CH_W-1:0]   err_ch_o
);
    vec_entry_t      tbl [NUM_CH];
    vec_entry_t      out_q;
    logic            out_v_q;
    logic [CH_W-1:0] out_ch_q;
    logic            flag_q;
    logic [CH_W-1:0] err_ch_q;
    logic            par_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) tbl[i] <= '0;
        end else if (wr_en && (int'(wr_ch) < NUM_CH)) begin
            tbl[wr_ch] <= '{par: even_par(wdata) ^ par_flip, word: wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= '0;
            out_v_q  <= 1'b0;
            out_ch_q <= '0;
        end else begin
            out_v_q  <= sel_valid;
            out_ch_q <= sel_ch;
            out_q    <= (int'(sel_ch) < NUM_CH) ? tbl[sel_ch] : '0;
        end
    end

    assign par_bad = out_v_q && (^{out_q.par, out_q.word});

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q   <= 1'b0;
            err_ch_q <= '0;
        end else if (par_bad) begin
            flag_q   <= 1'b1;
            err_ch_q <= out_ch_q;
        end else if (flag_clr) begin
            flag_q   <= 1'b0;
        end
    end

    assign rd_word     = (int'(rd_ch) < NUM_CH) ? tbl[rd_ch].word : '0;
    assign vec_o       = out_q.word;
    assign vec_valid_o = out_v_q;
    assign flag_o      = flag_q;
    assign err_ch_o    = err_ch_q;
endmodule

// File: rtl/icm_top.sv
`timescale 1ns/1ps
module icm_top import icm_pkg::*; #(
    parameter int NUM_CH    = 96,
    parameter int FIXED_FIQ = 2,
    parameter int IDX_W     = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              vec_par_flip,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fiq_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  fiq_idx_o,
    output logic [IDX_W-1:0]  irq_idx_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_valid_o
);
    localparam int NUM_GRP = NUM_CH / GRP_W;

    logic [NUM_CH-1:0] pend_w, mask_w, fsel_w, fiq_vec, irq_vec;
    logic              ctrl_we, tbl_we, flag_clr, flag_w, sel_valid;
    logic [7:0]        off_w;
    logic [CH_W-1:0]   sel_ch, err_ch_w, tbl_ch;
    logic [DATA_W-1:0] tbl_rd, err_addr;

    assign off_w   = bus_addr[7:0];
    assign tbl_ch  = bus_addr[ADDR_W-2:2];
    assign ctrl_we = bus_we && !bus_addr[ADDR_W-1] && !bus_addr[ADDR_W-2];
    assign tbl_we  = bus_we && bus_addr[ADDR_W-1];
    assign flag_clr = ctrl_we && (off_w == OFF_PFLAG) && bus_wdata[0];

    icm_req_bank #(.NUM_CH(NUM_CH), .FIXED_FIQ(FIXED_FIQ)) u_bank (
        .clk(clk), .rst(rst), .req_in(req_in),
        .wr_en(ctrl_we), .wr_off(off_w), .wdata(bus_wdata),
        .pend_o(pend_w), .mask_o(mask_w), .fsel_o(fsel_w)
    );

    assign fiq_vec = pend_w & mask_w & fsel_w;
    assign irq_vec = pend_w & mask_w & ~fsel_w;

    icm_prio_enc #(.N(NUM_CH), .IDX_W(IDX_W)) u_enc_fiq (.vec(fiq_vec), .idx(fiq_idx_o));
    icm_prio_enc #(.N(NUM_CH), .IDX_W(IDX_W)) u_enc_irq (.vec(irq_vec), .idx(irq_idx_o));

    assign fiq_o = |fiq_vec;
    assign irq_o = |irq_vec;

    always_comb begin
        sel_valid = 1'b1;
        if (fiq_idx_o != '0)
            sel_ch = CH_W'(fiq_idx_o - 1'b1);
        else if (irq_idx_o != '0)
            sel_ch = CH_W'(irq_idx_o - 1'b1);
        else begin
            sel_ch    = '0;
            sel_valid = 1'b0;
        end
    end

    icm_vec_table #(.NUM_CH(NUM_CH)) u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_ch(tbl_ch), .wdata(bus_wdata), .par_flip(vec_par_flip),
        .rd_ch(tbl_ch), .rd_word(tbl_rd),
        .sel_valid(sel_valid), .sel_ch(sel_ch),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o),
        .flag_clr(flag_clr), .flag_o(flag_w), .err_ch_o(err_ch_w)
    );

    assign err_addr = DATA_W'({err_ch_w, 2'b00});

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata = tbl_rd;
        end else if (!bus_addr[ADDR_W-2]) begin
            case (off_w)
                OFF_FIQIDX: bus_rdata = DATA_W'(fiq_idx_o);
                OFF_IRQIDX: bus_rdata = DATA_W'(irq_idx_o);
                OFF_PFLAG:  bus_rdata = DATA_W'(flag_w);
                OFF_PADDR:  bus_rdata = err_addr;
                default:    bus_rdata = '0;
            endcase
            for (int g = 0; g < NUM_GRP; g++) begin
                if (off_w == grp_off(OFF_MSET, g) || off_w == grp_off(OFF_MCLR, g))
                    bus_rdata = mask_w[g*GRP_W +: GRP_W];
                if (off_w == grp_off(OFF_PSEL, g))
                    bus_rdata = fsel_w[g*GRP_W +: GRP_W];
                if (off_w == grp_off(OFF_RCLR, g))
                    bus_rdata = pend_w[g*GRP_W +: GRP_W];
            end
        end
    end
endmodule

// File: rtl/icm_checker.sv
`timescale 1ns/1ps
module icm_checker import icm_pkg::*; #(
    parameter int NUM_CH    = 96,
    parameter int FIXED_FIQ = 2,
    parameter int IDX_W     = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              fiq_o,
    input logic              irq_o,
    input logic [IDX_W-1:0]  fiq_idx_o,
    input logic [IDX_W-1:0]  irq_idx_o,
    input logic [NUM_CH-1:0] mask_w,
    input logic              flag_w
);
    logic wr_mset0, wr_mclr0, wr_fclr;
    assign wr_mset0 = bus_we && (bus_addr == {2'b00, OFF_MSET});
    assign wr_mclr0 = bus_we && (bus_addr == {2'b00, OFF_MCLR});
    assign wr_fclr  = bus_we && (bus_addr == {2'b00, OFF_PFLAG}) && bus_wdata[0];

    AST_FIQ_LINE: assert property (@(posedge clk) disable iff (rst)
        fiq_o == (fiq_idx_o != '0)); // R7
    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
        irq_o == (irq_idx_o != '0)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(fiq_idx_o) <= NUM_CH) && (int'(irq_idx_o) <= NUM_CH)); // R5
    AST_FORCED_FAST: assert property (@(posedge clk) disable iff (rst)
        (int'(irq_idx_o) == 0) || (int'(irq_idx_o) > FIXED_FIQ)); // R6
    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        wr_mset0 |=> ((mask_w[GRP_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        wr_mclr0 |=> ((mask_w[GRP_W-1:0] & $past(bus_wdata)) == '0)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_w && !wr_fclr) |=> flag_w); // R10
endmodule

bind icm_top icm_checker #(.NUM_CH(NUM_CH), .FIXED_FIQ(FIXED_FIQ), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fiq_o(fiq_o), .irq_o(irq_o), .fiq_idx_o(fiq_idx_o), .irq_idx_o(irq_idx_o),
    .mask_w(u_bank.mask_o), .flag_w(u_tbl.flag_o)
);

// File: tb/tb_icm_top.sv
`timescale 1ns/1ps
module tb_icm_top;
    localparam int NCH = 96;
    localparam int K_RD = 0, K_FIDX = 1, K_IIDX = 2, K_VEC = 3, K_LINES = 4, K_VVAL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NCH-1:0] req_in = '0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        vec_par_flip = 1'b0;
    logic [31:0] bus_rdata, vec_o;
    logic        fiq_o, irq_o, vec_valid_o;
    logic [6:0]  fiq_idx_o, irq_idx_o;

    always #4 clk = ~clk;

    icm_top dut (
        .clk(clk), .rst(rst), .req_in(req_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .vec_par_flip(vec_par_flip), .bus_rdata(bus_rdata),
        .fiq_o(fiq_o), .irq_o(irq_o), .fiq_idx_o(fiq_idx_o), .irq_idx_o(irq_idx_o),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [31:0] sample(input int kind);
        case (kind)
            K_RD:    return bus_rdata;
            K_FIDX:  return 32'(fiq_idx_o);
            K_IIDX:  return 32'(irq_idx_o);
            K_VEC:   return vec_o;
            K_LINES: return {30'd0, fiq_o, irq_o};
            default: return 32'(vec_valid_o);
        endcase
    endfunction

    // monitor: pops expected items and compares them well away from the edge
    initial forever begin
        @(negedge clk);
        #3;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = sample(it.kind);
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [9:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = addr;
        q.push_back('{kind: kind, exp: exp, tag: tag});
        @(posedge clk);
    endtask

    task automatic wr(input logic [9:0] addr, input logic [31:0] data, input logic flip);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = addr;
        bus_wdata = data;
        vec_par_flip = flip;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        vec_par_flip = 1'b0;
    endtask

    task automatic set_req(input int ch, input logic v);
        @(negedge clk);
        req_in[ch] = v;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [9:0] vaddr(input int ch);
        return 10'h200 | 10'(ch * 4);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(K_RD, 10'h010, 32'h0, "R1 enable group0");
        chk(K_RD, 10'h018, 32'h0, "R1 enable group2");
        chk(K_RD, 10'h000, 32'h0, "R1 fast index reg");
        chk(K_RD, 10'h004, 32'h0, "R1 normal index reg");
        chk(K_RD, 10'h008, 32'h0, "R1 parity flag");
        chk(K_RD, 10'h030, 32'h3, "R1 path select group0");
        chk(K_RD, 10'h040, 32'h0, "R1 pending group0");
        chk(K_LINES, 10'h0, 32'h0, "R1 request lines");
        chk(K_VVAL, 10'h0, 32'h0, "R1 vec_valid");

        // R2 set register
        wr(10'h010, 32'h0000_00F0, 1'b0);
        chk(K_RD, 10'h010, 32'h0000_00F0, "R2 set bits");
        wr(10'h010, 32'h0, 1'b0);
        chk(K_RD, 10'h010, 32'h0000_00F0, "R2 zero write no effect");
        wr(10'h018, 32'h8000_0000, 1'b0);
        chk(K_RD, 10'h028, 32'h8000_0000, "R2 group2 via clear readback");

        // R3 clear register
        wr(10'h020, 32'h0000_0010, 1'b0);
        chk(K_RD, 10'h010, 32'h0000_00E0, "R3 clear bit4");
        wr(10'h020, 32'h0, 1'b0);
        chk(K_RD, 10'h020, 32'h0000_00E0, "R3 zero write no effect");

        // vector table contents
        wr(vaddr(6), 32'hA5A5_0006, 1'b0);
        wr(vaddr(95), 32'h1234_0095, 1'b0);
        wr(vaddr(0), 32'hC0DE_0000, 1'b0);
        chk(K_RD, vaddr(95), 32'h1234_0095, "R8 table readback");

        // R5 priority, boundary channel 95
        set_req(95, 1'b1);
        chk(K_IIDX, 10'h0, 32'd96, "R5 channel 95 index");
        chk(K_LINES, 10'h0, 32'h1, "R7 normal line only");
        set_req(6, 1'b1);
        chk(K_RD, 10'h004, 32'd7, "R5 lower channel wins");
        set_req(4, 1'b1);
        chk(K_IIDX, 10'h0, 32'd7, "R5 disabled channel not reported");
        chk(K_RD, 10'h040, 32'h0000_0050, "R4 disabled channel pending");

        // R6 path steering
        wr(10'h030, 32'h0000_0040, 1'b0);
        chk(K_FIDX, 10'h0, 32'd7, "R6 channel 6 on fast path");
        chk(K_IIDX, 10'h0, 32'd96, "R6 normal path left with 95");
        chk(K_RD, 10'h030, 32'h0000_0043, "R6 select readback");
        chk(K_LINES, 10'h0, 32'h3, "R7 both lines");
        chk(K_VEC, 10'h0, 32'hA5A5_0006, "R8 fast path vector first");
        chk(K_VVAL, 10'h0, 32'h1, "R8 vec_valid");

        // R4 clearing and edge-only latching
        wr(10'h040, 32'h0, 1'b0);
        chk(K_RD, 10'h040, 32'h0000_0050, "R4 zero clear no effect");
        wr(10'h040, 32'h0000_0040, 1'b0);
        chk(K_FIDX, 10'h0, 32'd0, "R4 held request not relatched");
        chk(K_RD, 10'h040, 32'h0000_0010, "R4 pending after clear");
        chk(K_VEC, 10'h0, 32'h1234_0095, "R8 vector follows normal path");
        set_req(6, 1'b0);
        set_req(6, 1'b1);
        chk(K_FIDX, 10'h0, 32'd7, "R4 new edge relatches");
        wr(10'h040, 32'h0000_0040, 1'b0);

        // R9 parity fault on channel 95
        wr(vaddr(95), 32'h1234_0095, 1'b1);
        idle(2);
        chk(K_RD, 10'h008, 32'h1, "R9 parity flag set");
        chk(K_RD, 10'h00C, 32'h0000_017C, "R9 error address");

        // R11 repair, R10 stickiness
        wr(vaddr(95), 32'h5555_0095, 1'b0);
        idle(2);
        wr(10'h008, 32'h0, 1'b0);
        chk(K_RD, 10'h008, 32'h1, "R10 zero write keeps flag");
        wr(10'h008, 32'h1, 1'b0);
        chk(K_RD, 10'h008, 32'h0, "R10 flag cleared");
        idle(3);
        chk(K_RD, 10'h008, 32'h0, "R11 no new error after rewrite");
        chk(K_VEC, 10'h0, 32'h5555_0095, "R11 repaired word read out");

        // channel 0: forced fast, highest priority, cleared by bit 0
        wr(10'h030, 32'h0, 1'b0);
        chk(K_RD, 10'h030, 32'h3, "R6 channels 0 and 1 forced fast");
        wr(10'h010, 32'h1, 1'b0);
        set_req(0, 1'b1);
        chk(K_FIDX, 10'h0, 32'd1, "R5 channel 0 fast index");
        idle(1);
        chk(K_VEC, 10'h0, 32'hC0DE_0000, "R8 channel 0 vector");
        wr(10'h040, 32'h1, 1'b0);
        chk(K_FIDX, 10'h0, 32'd0, "R4 channel 0 cleared");
        chk(K_IIDX, 10'h0, 32'd96, "R5 channel 95 still pending");

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule